// File: doc/BRIEF.md
# TCP/UDP Port Priority Classifier

This block gives every IP packet a transmit priority and a drop-eligibility flag. The decision depends only on the packet's TCP/UDP logical port number. The port is compared against eight exact-match entries, each of which can be switched on or off on its own. It is also compared against one port window whose bounds are exclusive.

Software sets up the classifier through a write-only, byte-wide configuration port. Packet-side logic presents a port number with a valid strobe. One clock later the block returns a registered result: a hit flag, a 3-bit priority and a drop bit.

Each priority setting is a 4-bit code. Bits [3:1] hold the priority and bit [0] is the drop flag. Two entries share each priority byte.

Top module: `port_prio_classifier`

## Requirements
- R1: After reset every configuration register is zero. The outputs `res_valid`, `res_hit`, `res_prio` and `res_drop` are zero, and a lookup of any port, including port 0, reports no hit.
- R2: An enabled exact entry matches a port equal to its 16-bit value. Entry i takes its low byte at address i (0x00–0x07) and its high byte at address 8+i (0x08–0x0F).
- R3: The enable byte at address 0x10 holds entry i's enable in bit i. A disabled entry never matches, even when its port value is equal to the input.
- R4: Priority bytes sit at addresses 0x11–0x14. Byte 0x11+k serves entry 2k in bits [3:0] and entry 2k+1 in bits [7:4]. In each 4-bit code, bits [3:1] are the reported priority and bit [0] is the drop flag.
- R5: When several enabled exact entries match, the lowest-numbered entry supplies the result.
- R6: The window's lower bound is written at 0x15 (low byte) and 0x16 (high byte). Its upper bound is written at 0x17 (low byte) and 0x18 (high byte). A port matches the window only when it is strictly above the lower bound and strictly below the upper bound. The window's code is taken from bits [3:0] of address 0x19.
- R7: The window never matches while the upper bound is less than or equal to the lower bound.
- R8: Any exact-entry hit takes precedence over a window hit.
- R9: A lookup that matches nothing reports `res_hit`=0, priority 0 and drop 0.
- R10: A configuration write in the same cycle as a lookup does not affect that lookup. It does affect every later lookup.
- R11: `res_valid` is high in exactly the cycle after `lkp_valid`. The result fields are zero whenever `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| lkp_valid | input | 1 | Lookup request strobe |
| lkp_port | input | 16 | TCP/UDP logical port to classify |
| res_valid | output | 1 | Result strobe, one cycle after the lookup |
| res_hit | output | 1 | A rule matched |
| res_prio | output | 3 | Assigned priority |
| res_drop | output | 1 | Drop-eligibility flag |

## Verification
Random configurations draw the entry values, the window bounds and the lookup ports from one narrow pool. This makes duplicate entries, entries inside the window, and ports on or next to the bounds all frequent, so mistakes in entry order, in exact-over-window precedence, and in strict versus inclusive bounds produce different outputs.

Directed lookups cover several cases:
- ports exactly on each bound;
- windows with equal bounds and with inverted bounds, which show whether the disable test is inclusive;
- a disabled entry holding the probed port;
- odd and even entries, which separate the two nibble positions;
- a write issued in the same cycle as a lookup, which shows when new settings take effect.

// File: rtl/port_cls_pkg.sv
`timescale 1ns/1ps
package port_cls_pkg;
    localparam int PORT_W    = 16;
    localparam int N_ENTRIES = 8;
    localparam int N_PBYTES  = N_ENTRIES / 2;
    localparam int ADDR_W    = 5;

    // configuration address map
    localparam logic [ADDR_W-1:0] A_PORT_LO = 5'h00;
    localparam logic [ADDR_W-1:0] A_PORT_HI = 5'h08;
    localparam logic [ADDR_W-1:0] A_ENABLE  = 5'h10;
    localparam logic [ADDR_W-1:0] A_PRIO    = 5'h11;
    localparam logic [ADDR_W-1:0] A_RLOW_L  = 5'h15;
    localparam logic [ADDR_W-1:0] A_RLOW_H  = 5'h16;
    localparam logic [ADDR_W-1:0] A_RUP_L   = 5'h17;
    localparam logic [ADDR_W-1:0] A_RUP_H   = 5'h18;
    localparam logic [ADDR_W-1:0] A_RCODE   = 5'h19;

    typedef logic [3:0] prio_code_t;

    typedef struct packed {
        logic       hit;
        logic [2:0] prio;
        logic       drop;
    } cls_result_t;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_EXACT = 2'd1,
        SRC_RANGE = 2'd2
    } cls_src_e;

    function automatic cls_result_t code_to_result(input prio_code_t code);
        cls_result_t r;
        r.hit  = 1'b1;
        r.prio = code[3:1];
        r.drop = code[0];
        return r;
    endfunction
endpackage

// File: rtl/pcls_regfile.sv
`timescale 1ns/1ps
module pcls_regfile
    import port_cls_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cfg_wr,
    input  logic [ADDR_W-1:0]                  cfg_addr,
    input  logic [7:0]                         cfg_wdata,
    output logic [N_ENTRIES-1:0][PORT_W-1:0]   ent_port,
    output logic [N_ENTRIES-1:0]               ent_en,
    output logic [N_PBYTES-1:0][7:0]           prio_byte,
    output logic [PORT_W-1:0]                  rng_low,
    output logic [PORT_W-1:0]                  rng_up,
    output prio_code_t                         rng_code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ent_port  <= '0;
            ent_en    <= '0;
            prio_byte <= '0;
            rng_low   <= '0;
            rng_up    <= '0;
            rng_code  <= '0;
        end else if (cfg_wr) begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                if (cfg_addr == A_PORT_LO + ADDR_W'(i))
                    ent_port[i][7:0] <= cfg_wdata;
                if (cfg_addr == A_PORT_HI + ADDR_W'(i))
                    ent_port[i][15:8] <= cfg_wdata;
            end
            for (int k = 0; k < N_PBYTES; k++) begin
                if (cfg_addr == A_PRIO + ADDR_W'(k))
                    prio_byte[k] <= cfg_wdata;
            end
            case (cfg_addr)
                A_ENABLE: ent_en         <= cfg_wdata[N_ENTRIES-1:0];
                A_RLOW_L: rng_low[7:0]   <= cfg_wdata;
                A_RLOW_H: rng_low[15:8]  <= cfg_wdata;
                A_RUP_L:  rng_up[7:0]    <= cfg_wdata;
                A_RUP_H:  rng_up[15:8]   <= cfg_wdata;
                A_RCODE:  rng_code       <= cfg_wdata[3:0];
                default: ;
            endcase
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (ent_en == '0 && rng_low == '0 && rng_up == '0));
endmodule

// File: rtl/pcls_exact_match.sv
`timescale 1ns/1ps
module pcls_exact_match
    import port_cls_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic [PORT_W-1:0]                 port,
    input  logic [N_ENTRIES-1:0][PORT_W-1:0]  ent_port,
    input  logic [N_ENTRIES-1:0]              ent_en,
    input  logic [N_PBYTES-1:0][7:0]          prio_byte,
    output logic                              found,
    output logic [$clog2(N_ENTRIES)-1:0]      idx,
    output prio_code_t                        code
);
    localparam int IDX_W = $clog2(N_ENTRIES);

    logic [N_ENTRIES-1:0] hit_vec;
    prio_code_t           ent_code [N_ENTRIES];

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
        assign hit_vec[g]  = ent_en[g] && (ent_port[g] == port);
        assign ent_code[g] = prio_byte[g/2][(g%2)*4 +: 4];
    end

    // lowest-numbered hit wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

    assign code = ent_code[idx];

    // R3
    exact_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        found |-> (ent_en[idx] && ent_port[idx] == port));

    // R5
    exact_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        found |-> ((hit_vec & ((N_ENTRIES'(1) << idx) - N_ENTRIES'(1))) == '0));
endmodule

// File: rtl/pcls_range_match.sv
`timescale 1ns/1ps
module pcls_range_match
    import port_cls_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] port,
    input  logic [PORT_W-1:0] rng_low,
    input  logic [PORT_W-1:0] rng_up,
    output logic              in_range
);
    logic window_on;

    assign window_on = rng_up > rng_low;
    assign in_range  = window_on && (port > rng_low) && (port < rng_up);

    // R6
    range_bounds_chk: assert property (@(posedge clk) disable iff (rst)
        in_range |-> (port != rng_low && port != rng_up));

    // R7
    range_order_chk: assert property (@(posedge clk) disable iff (rst)
        (rng_up <= rng_low) |-> !in_range);
endmodule

// File: rtl/port_prio_classifier.sv
`timescale 1ns/1ps
module port_prio_classifier
    import port_cls_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [4:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              lkp_valid,
    input  logic [15:0]       lkp_port,
    output logic              res_valid,
    output logic              res_hit,
    output logic [2:0]        res_prio,
    output logic              res_drop
);
    logic [N_ENTRIES-1:0][PORT_W-1:0] ent_port;
    logic [N_ENTRIES-1:0]             ent_en;
    logic [N_PBYTES-1:0][7:0]         prio_byte;
    logic [PORT_W-1:0]                rng_low, rng_up;
    prio_code_t                       rng_code;

    logic                         ex_found;
    logic [$clog2(N_ENTRIES)-1:0] ex_idx;
    prio_code_t                   ex_code;
    logic                         rg_hit;

    cls_src_e    src;
    cls_result_t sel_res, res_q;
    logic        vld_q;

    pcls_regfile u_regs (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .ent_port(ent_port), .ent_en(ent_en), .prio_byte(prio_byte),
        .rng_low(rng_low), .rng_up(rng_up), .rng_code(rng_code)
    );

    pcls_exact_match u_exact (
        .clk(clk), .rst(rst), .port(lkp_port),
        .ent_port(ent_port), .ent_en(ent_en), .prio_byte(prio_byte),
        .found(ex_found), .idx(ex_idx), .code(ex_code)
    );

    pcls_range_match u_range (
        .clk(clk), .rst(rst), .port(lkp_port),
        .rng_low(rng_low), .rng_up(rng_up), .in_range(rg_hit)
    );

    always_comb begin
        if (ex_found)    src = SRC_EXACT;
        else if (rg_hit) src = SRC_RANGE;
        else             src = SRC_NONE;
        case (src)
            SRC_EXACT: sel_res = code_to_result(ex_code);
            SRC_RANGE: sel_res = code_to_result(rng_code);
            default:   sel_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= lkp_valid;
            res_q <= lkp_valid ? sel_res : '0;
        end
    end

    assign res_valid = vld_q;
    assign res_hit   = res_q.hit;
    assign res_prio  = res_q.prio;
    assign res_drop  = res_q.drop;

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        lkp_valid |=> res_valid);

    // R11
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !lkp_valid |=> (!res_valid && !res_hit && res_prio == 3'd0 && !res_drop));

    // R9
    nomatch_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_prio == 3'd0 && !res_drop));

    // R8
    exact_first_chk: assert property (@(posedge clk) disable iff (rst)
        (lkp_valid && ex_found) |=> (res_hit && {res_prio, res_drop} == $past(ex_code)));
endmodule

// File: tb/port_prio_classifier_test.sv
`timescale 1ns/1ps
module port_prio_classifier_test;
    logic        clk = 0;
    logic        rst;
    logic        cfg_wr;
    logic [4:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic        lkp_valid;
    logic [15:0] lkp_port;
    logic        res_valid, res_hit, res_drop;
    logic [2:0]  res_prio;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // bench model of the configuration
    logic [15:0] m_port [8];
    logic [7:0]  m_en;
    logic [7:0]  m_pb [4];
    logic [15:0] m_low, m_up;
    logic [3:0]  m_rcode;

    always #2 clk = ~clk;

    port_prio_classifier uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .lkp_valid(lkp_valid), .lkp_port(lkp_port),
        .res_valid(res_valid), .res_hit(res_hit), .res_prio(res_prio),
        .res_drop(res_drop)
    );

    // expected {valid, hit, prio, drop}
    function automatic logic [5:0] expect_of(input logic [15:0] p);
        for (int i = 0; i < 8; i++) begin
            if (m_en[i] && m_port[i] == p) begin
                logic [3:0] c;
                c = (i % 2 == 0) ? m_pb[i/2][3:0] : m_pb[i/2][7:4];
                return {2'b11, c};
            end
        end
        if (m_up > m_low && p > m_low && p < m_up)
            return {2'b11, m_rcode};
        return 6'b100000;
    endfunction

    task automatic model_write(input logic [4:0] a, input logic [7:0] d);
        if (a < 5'h08)       m_port[a][7:0] = d;
        else if (a < 5'h10)  m_port[a-8][15:8] = d;
        else if (a == 5'h10) m_en = d;
        else if (a < 5'h15)  m_pb[a-5'h11] = d;
        else if (a == 5'h15) m_low[7:0] = d;
        else if (a == 5'h16) m_low[15:8] = d;
        else if (a == 5'h17) m_up[7:0] = d;
        else if (a == 5'h18) m_up[15:8] = d;
        else if (a == 5'h19) m_rcode = d[3:0];
    endtask

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got v/h/prio/drop=%b expected %b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 0;
        model_write(a, d);
    endtask

    task automatic wr16(input logic [4:0] alo, input logic [4:0] ahi, input logic [15:0] v);
        wr(alo, v[7:0]);
        wr(ahi, v[15:8]);
    endtask

    task automatic lookup(input string req, input logic [15:0] p);
        logic [5:0] e;
        @(negedge clk);
        lkp_valid = 1; lkp_port = p;
        e = expect_of(p);
        @(negedge clk);
        lkp_valid = 0;
        check(req, {res_valid, res_hit, res_prio, res_drop}, e);
    endtask

    task automatic clear_cfg();
        for (int i = 0; i < 8; i++) wr16(5'(i), 5'(8 + i), 16'h0000);
        wr(5'h10, 8'h00);
        for (int k = 0; k < 4; k++) wr(5'(5'h11 + k), 8'h00);
        wr16(5'h15, 5'h16, 16'h0000);
        wr16(5'h17, 5'h18, 16'h0000);
        wr(5'h19, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [5:0] e;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) m_port[i] = 0;
        for (int k = 0; k < 4; k++) m_pb[k] = 0;
        m_en = 0; m_low = 0; m_up = 0; m_rcode = 0;
        rst = 1; cfg_wr = 0; cfg_addr = 0; cfg_wdata = 0; lkp_valid = 0; lkp_port = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state of the outputs and of the rules
        check("R1", {res_valid, res_hit, res_prio, res_drop}, 6'b000000);
        lookup("R1", 16'h0000);
        lookup("R1", 16'd80);

        // R2 / R4: even and odd entries, separating the two nibbles
        wr16(5'h00, 5'h08, 16'd80);
        wr16(5'h01, 5'h09, 16'd443);
        wr(5'h11, 8'hA7);
        wr(5'h10, 8'h03);
        lookup("R2", 16'd80);
        lookup("R4", 16'd443);
        wr16(5'h07, 5'h0F, 16'hBEEF);
        wr(5'h14, 8'h3C);
        wr(5'h10, 8'h83);
        lookup("R4", 16'hBEEF);
        lookup("R9", 16'd81);

        // R3: a disabled entry holding the probed port
        wr(5'h10, 8'h02);
        lookup("R3", 16'd80);
        @(negedge clk);
        check("R11", {res_valid, res_hit, res_prio, res_drop}, 6'b000000);

        // R5: duplicate entries, the lower index wins
        clear_cfg();
        wr16(5'h02, 5'h0A, 16'd5000);
        wr16(5'h05, 5'h0D, 16'd5000);
        wr(5'h12, 8'h0B);
        wr(5'h13, 8'hE0);
        wr(5'h10, 8'h24);
        lookup("R5", 16'd5000);
        wr(5'h10, 8'h20);
        lookup("R5", 16'd5000);

        // R6: strict bounds of the window
        wr16(5'h15, 5'h16, 16'd1000);
        wr16(5'h17, 5'h18, 16'd1010);
        wr(5'h19, 8'h09);
        lookup("R6", 16'd1000);
        lookup("R6", 16'd1001);
        lookup("R6", 16'd1009);
        lookup("R6", 16'd1010);

        // R8: an exact entry inside the window
        wr16(5'h00, 5'h08, 16'd1005);
        wr(5'h11, 8'h04);
        wr(5'h10, 8'h21);
        lookup("R8", 16'd1005);
        lookup("R8", 16'd1006);

        // R7: equal and inverted bounds disable the window
        wr16(5'h17, 5'h18, 16'd1000);
        lookup("R7", 16'd1000);
        lookup("R7", 16'd1003);
        wr16(5'h17, 5'h18, 16'd900);
        lookup("R7", 16'd950);
        lookup("R7", 16'd1003);

        // R10: a write in the same cycle as a lookup
        @(negedge clk);
        lkp_valid = 1; lkp_port = 16'd1005;
        cfg_wr = 1; cfg_addr = 5'h10; cfg_wdata = 8'h00;
        e = expect_of(16'd1005);
        @(negedge clk);
        lkp_valid = 0; cfg_wr = 0;
        check("R10", {res_valid, res_hit, res_prio, res_drop}, e);
        model_write(5'h10, 8'h00);
        lookup("R10", 16'd1005);

        // random configurations over a narrow port pool
        for (int r = 0; r < 25; r++) begin
            for (int i = 0; i < 8; i++)
                wr16(5'(i), 5'(8 + i), 16'(16'd200 + ($urandom % 12)));
            for (int k = 0; k < 4; k++) wr(5'(5'h11 + k), 8'($urandom));
            wr16(5'h15, 5'h16, 16'(16'd198 + ($urandom % 16)));
            wr16(5'h17, 5'h18, 16'(16'd198 + ($urandom % 16)));
            wr(5'h19, 8'($urandom));
            wr(5'h10, 8'($urandom));
            for (int t = 0; t < 24; t++)
                lookup("R2 R5 R6 R7 R8", 16'(16'd196 + ($urandom % 20)));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule